// File: doc/BRIEF.md
# Event Interrupt Controller with Level/Pulse Output

This block gathers the event indications of a USB device controller into one sticky status word and turns that word into a single interrupt line. There are six bus-level events: bus reset, suspend, resume, start-of-frame, end-of-transfer and short-packet end-of-transfer. There are also sixteen endpoint events: control OUT, control IN and fourteen data endpoints. Every status bit has its own enable bit. A global enable gates the combined request. A mode bit chooses how the line signals: it either follows the request as a level, or it emits one fixed-width pulse each time the request rises.

Status bits clear as side effects of reads on the surrounding register bus. A strobe for the interrupt register read clears the six bus-level bits. It leaves the endpoint bits alone, and each endpoint bit clears only on its own endpoint-status read strobe. The read word also carries a live bus-status bit, which is never latched. A data endpoint that has not been configured cannot log events. The two control endpoints always can.

Top module: `evt_irq_hub`

## Requirements
- R1: An event pulse sets its status bit at the next clock edge, and the bit stays set until it is cleared. The status layout is: bits 0..5 = bus reset, suspend, resume, start-of-frame, end-of-transfer, short end-of-transfer (`bus_evt_i` bits 0..5); bit 6 = control OUT; bit 7 = control IN; bit 7+k = data endpoint k, for k = 1..14 (`ep_evt_i` bit j maps to status bit 6+j).
- R2: An event on data endpoint k is ignored while `ep_cfg_en_i[k-1]` is 0. Control OUT and control IN events are always accepted.
- R3: `int_rdata_o` is `{bus_status_i, status[21:0]}` in the same cycle as the read. The clock edge that samples `int_rd_i` clears status bits 0..5 and leaves bits 6..21 unchanged.
- R4: The edge that samples `ep_rd_i[j]` clears status bit 6+j only.
- R5: An event and the clear for its bit in the same cycle leave the bit set.
- R6: Only status bits whose enable bit (written through `en_we_i`/`en_wdata_i`, same layout as R1) is 1 contribute to the request.
- R7: While the global enable is 0, the line never asserts in level mode.
- R8: Level mode (`cfg_pulse_i` = 0) is the reset default. In this mode `irq_o` is high exactly one cycle after the request is high, and it stays high while the request does.
- R9: In pulse mode, a rise of the request drives `irq_o` high for exactly PULSE_CYC cycles, starting the cycle after the rise. A request that stays high gives no further pulse.
- R10: A new rise of the request while a pulse runs neither restarts nor lengthens it.
- R11: Reset clears all status bits, all enable bits, the global enable and the mode bit, and holds `irq_o` low.
- R12: Bit 22 of `int_rdata_o` follows `bus_status_i` combinationally, with no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_evt_i | input | 6 | Bus-level event pulses |
| ep_evt_i | input | 16 | Endpoint event pulses |
| ep_cfg_en_i | input | 14 | Data endpoint configured flags |
| int_rd_i | input | 1 | Interrupt register read strobe |
| ep_rd_i | input | 16 | Per-endpoint status read strobes |
| bus_status_i | input | 1 | Live bus status |
| en_we_i | input | 1 | Enable mask write strobe |
| en_wdata_i | input | 22 | Enable mask write data |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_glob_en_i | input | 1 | Global interrupt enable write data |
| cfg_pulse_i | input | 1 | Pulse mode select write data |
| int_rdata_o | output | 23 | Interrupt register read word |
| irq_o | output | 1 | Interrupt line |

## Verification
The pulse-start assertion assumes that the mode bit does not change during the cycle in which the request rises. The level-mode masking assertion is written so that it still holds across a mode change. The stimulus rewrites the configuration only while every status bit is clear, so the request is low whenever the mode changes. Every input is driven as a synchronous one-cycle pulse away from the active edge. The assertions also take for granted that events and read strobes are registered outputs of neighbouring logic and never glitch within a cycle. The bench sweeps every status bit with its enable on and off, and it covers both clear paths for each one.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned BUS_EVT_N = 6;
  localparam int unsigned CTRL_EP_N = 2;

  typedef enum logic [2:0] {
    BEV_BUS_RESET = 3'd0,
    BEV_SUSPEND   = 3'd1,
    BEV_RESUME    = 3'd2,
    BEV_SOF       = 3'd3,
    BEV_EOT       = 3'd4,
    BEV_SHORT_EOT = 3'd5
  } bus_evt_e;

  typedef struct packed {
    logic glob_en;
    logic pulse_mode;
  } irq_cfg_t;

  function automatic int unsigned stat_width(input int unsigned data_ep_n);
    return BUS_EVT_N + CTRL_EP_N + data_ep_n;
  endfunction

endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);

  logic [WIDTH-1:0] st_q;
  logic [WIDTH-1:0] st_nxt;
  logic [WIDTH-1:0] st_ce;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      st_ce[i]  = set_i[i] | clr_i[i];
      st_nxt[i] = set_i[i] | (st_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= 1'b0;
      end else if (st_ce[i]) begin
        st_q[i] <= st_nxt[i];
      end
    end
  end

  assign status_o = st_q;

  // R5: a set in the same cycle as a clear keeps the bit
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((st_q & $past(set_i)) == $past(set_i)));

  // R3 and R4: a clear without a set empties the bit
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((st_q & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import evt_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  input  logic             cfg_we_i,
  input  irq_cfg_t         cfg_wdata_i,
  input  logic [WIDTH-1:0] status_i,
  output logic             req_o,
  output irq_cfg_t         cfg_o
);

  logic [WIDTH-1:0] en_q;
  logic [WIDTH-1:0] en_nxt;
  irq_cfg_t         cfg_q;
  irq_cfg_t         cfg_nxt;

  always_comb begin
    en_nxt  = en_wdata_i;
    cfg_nxt = cfg_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we_i) begin
      en_q <= en_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q <= cfg_nxt;
    end
  end

  assign req_o = cfg_q.glob_en & (|(status_i & en_q));
  assign cfg_o = cfg_q;

endmodule

// File: rtl/irq_out_shaper.sv
module irq_out_shaper #(
  parameter int unsigned PULSE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic pulse_mode_i,
  output logic irq_o
);

  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

  logic             req_q;
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_ce;
  logic             rise;
  logic             busy;

  always_comb begin
    rise    = req_i & ~req_q;
    busy    = (cnt_q != '0);
    cnt_nxt = cnt_q;
    cnt_ce  = 1'b0;
    if (busy) begin
      cnt_nxt = cnt_q - 1'b1;
      cnt_ce  = 1'b1;
    end else if (pulse_mode_i && rise) begin
      cnt_nxt = CNT_W'(PULSE_CYC);
      cnt_ce  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      req_q <= req_i;
      lvl_q <= req_i & ~pulse_mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign irq_o = pulse_mode_i ? busy : lvl_q;

  // R9: an idle rise in pulse mode asserts the line on the next cycle
  p_pulse_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode_i && rise && !busy) |=> (irq_o || !pulse_mode_i));

  // R10: a running pulse only counts down
  p_no_retrigger_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_DATA_EP = 14,
  parameter int unsigned PULSE_CYC   = 8
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [BUS_EVT_N-1:0]                      bus_evt_i,
  input  logic [CTRL_EP_N+NUM_DATA_EP-1:0]          ep_evt_i,
  input  logic [NUM_DATA_EP-1:0]                    ep_cfg_en_i,
  input  logic                                      int_rd_i,
  input  logic [CTRL_EP_N+NUM_DATA_EP-1:0]          ep_rd_i,
  input  logic                                      bus_status_i,
  input  logic                                      en_we_i,
  input  logic [BUS_EVT_N+CTRL_EP_N+NUM_DATA_EP-1:0] en_wdata_i,
  input  logic                                      cfg_we_i,
  input  logic                                      cfg_glob_en_i,
  input  logic                                      cfg_pulse_i,
  output logic [BUS_EVT_N+CTRL_EP_N+NUM_DATA_EP:0]  int_rdata_o,
  output logic                                      irq_o
);

  localparam int unsigned EP_N = CTRL_EP_N + NUM_DATA_EP;
  localparam int unsigned ST_W = stat_width(NUM_DATA_EP);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int = rst_sync_q[1];

  logic [EP_N-1:0] ep_active;
  logic [ST_W-1:0] set_vec;
  logic [ST_W-1:0] clr_vec;
  logic [ST_W-1:0] stat_q;
  logic            req;
  irq_cfg_t        cfg_wr;
  irq_cfg_t        cfg;

  always_comb begin
    ep_active = {ep_cfg_en_i, {CTRL_EP_N{1'b1}}};
    set_vec   = {ep_evt_i & ep_active, bus_evt_i};
    clr_vec   = {ep_rd_i, {BUS_EVT_N{int_rd_i}}};
    cfg_wr    = '{glob_en: cfg_glob_en_i, pulse_mode: cfg_pulse_i};
  end

  evt_status_bank #(
    .WIDTH (ST_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_int),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .status_o (stat_q)
  );

  irq_mask_unit #(
    .WIDTH (ST_W)
  ) u_mask (
    .clk         (clk),
    .rst_n       (rst_int),
    .en_we_i     (en_we_i),
    .en_wdata_i  (en_wdata_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wr),
    .status_i    (stat_q),
    .req_o       (req),
    .cfg_o       (cfg)
  );

  irq_out_shaper #(
    .PULSE_CYC (PULSE_CYC)
  ) u_shape (
    .clk          (clk),
    .rst_n        (rst_int),
    .req_i        (req),
    .pulse_mode_i (cfg.pulse_mode),
    .irq_o        (irq_o)
  );

  assign int_rdata_o = {bus_status_i, stat_q};

  // R2: an endpoint bit only rises after an accepted event
  p_ep_gate_r2: assert property (@(posedge clk) disable iff (!rst_int)
    ((stat_q[ST_W-1:BUS_EVT_N] & ~$past(stat_q[ST_W-1:BUS_EVT_N]))
      & ~$past(ep_evt_i & ep_active)) == '0);

  // R3: the interrupt register read leaves endpoint bits intact
  p_ep_keep_r3: assert property (@(posedge clk) disable iff (!rst_int)
    int_rd_i |=> ((stat_q[ST_W-1:BUS_EVT_N]
      & $past(stat_q[ST_W-1:BUS_EVT_N] & ~ep_rd_i))
      == $past(stat_q[ST_W-1:BUS_EVT_N] & ~ep_rd_i)));

  // R7: global enable low keeps the level-mode line quiet
  p_glob_mask_r7: assert property (@(posedge clk) disable iff (!rst_int)
    (!cfg.glob_en && !cfg.pulse_mode) |=> (!irq_o || cfg.pulse_mode));

endmodule

// File: tb/evt_irq_hub_test.sv
module evt_irq_hub_test;

  localparam int PW   = 8;
  localparam int NDE  = 14;
  localparam int NEP  = 16;
  localparam int STW  = 22;

  logic             clk;
  logic             rst_n;
  logic [5:0]       bus_evt;
  logic [NEP-1:0]   ep_evt;
  logic [NDE-1:0]   ep_cfg_en;
  logic             int_rd;
  logic [NEP-1:0]   ep_rd;
  logic             bus_status;
  logic             en_we;
  logic [STW-1:0]   en_wdata;
  logic             cfg_we;
  logic             cfg_glob;
  logic             cfg_pulse;
  logic [STW:0]     rdata;
  logic             irq;

  int checks;
  int errors;

  evt_irq_hub #(.NUM_DATA_EP(NDE), .PULSE_CYC(PW)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_evt_i    (bus_evt),
    .ep_evt_i     (ep_evt),
    .ep_cfg_en_i  (ep_cfg_en),
    .int_rd_i     (int_rd),
    .ep_rd_i      (ep_rd),
    .bus_status_i (bus_status),
    .en_we_i      (en_we),
    .en_wdata_i   (en_wdata),
    .cfg_we_i     (cfg_we),
    .cfg_glob_en_i(cfg_glob),
    .cfg_pulse_i  (cfg_pulse),
    .int_rdata_o  (rdata),
    .irq_o        (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fire(input int idx);
    if (idx < 6) bus_evt[idx] = 1'b1;
    else ep_evt[idx-6] = 1'b1;
    cyc();
    bus_evt = '0;
    ep_evt  = '0;
  endtask

  task automatic wr_en(input logic [STW-1:0] m);
    en_we = 1'b1; en_wdata = m;
    cyc();
    en_we = 1'b0;
  endtask

  task automatic wr_cfg(input logic g, input logic p);
    cfg_we = 1'b1; cfg_glob = g; cfg_pulse = p;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic clr_all();
    int_rd = 1'b1; ep_rd = '1;
    cyc();
    int_rd = 1'b0; ep_rd = '0;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [STW-1:0] oh;
    int n;
    checks = 0; errors = 0;
    rst_n = 1'b0; bus_evt = '0; ep_evt = '0; ep_cfg_en = '1;
    int_rd = 1'b0; ep_rd = '0; bus_status = 1'b0;
    en_we = 1'b0; en_wdata = '0; cfg_we = 1'b0; cfg_glob = 1'b0; cfg_pulse = 1'b0;
    repeat (4) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R11: reset state
    chk("R11 status after reset", 32'(rdata[STW-1:0]), 32'h0);
    chk("R11 irq after reset", 32'(irq), 32'h0);
    // R11: enables start cleared, so a logged event raises nothing
    wr_cfg(1'b1, 1'b0);
    fire(3);
    cyc();
    chk("R11 enables cleared irq", 32'(irq), 32'h0);
    clr_all();

    // sweep every status bit
    for (int i = 0; i < STW; i++) begin
      oh = STW'(1) << i;
      wr_en(~oh);
      fire(i);
      chk("R1 sticky set", 32'(rdata[STW-1:0]), 32'(oh));
      cyc();
      chk("R6 disabled bit no irq", 32'(irq), 32'h0);
      chk("R1 bit held", 32'(rdata[STW-1:0]), 32'(oh));
      wr_en('1);
      chk("R8 level latency low", 32'(irq), 32'h0);
      cyc();
      chk("R8 level high", 32'(irq), 32'h1);
      int_rd = 1'b1;
      chk("R3 read word before clear", 32'(rdata[STW-1:0]), 32'(oh));
      cyc();
      int_rd = 1'b0;
      if (i < 6) begin
        chk("R3 bus bit cleared by read", 32'(rdata[STW-1:0]), 32'h0);
      end else begin
        chk("R3 endpoint bit kept on read", 32'(rdata[STW-1:0]), 32'(oh));
        ep_rd[i-6] = 1'b1;
        cyc();
        ep_rd = '0;
        chk("R4 endpoint bit cleared", 32'(rdata[STW-1:0]), 32'h0);
      end
      cyc();
      chk("R8 level falls", 32'(irq), 32'h0);
    end

    // R4: another endpoint's read leaves this one alone
    ep_evt[0] = 1'b1; ep_evt[4] = 1'b1;
    cyc(); ep_evt = '0;
    ep_rd[0] = 1'b1;
    cyc(); ep_rd = '0;
    chk("R4 selective clear", 32'(rdata[STW-1:0]), 32'h1 << 10);
    clr_all();

    // R2: endpoint gating
    ep_cfg_en = '0;
    ep_evt = '1;
    cyc(); ep_evt = '0;
    chk("R2 only control endpoints", 32'(rdata[STW-1:0]), 32'h3 << 6);
    clr_all();
    ep_cfg_en = 14'h0001;
    ep_evt = '1;
    cyc(); ep_evt = '0;
    chk("R2 data ep1 enabled", 32'(rdata[STW-1:0]), 32'h7 << 6);
    clr_all();
    ep_cfg_en = '1;

    // R5: set wins over clear
    bus_evt[3] = 1'b1; int_rd = 1'b1; ep_evt[2] = 1'b1; ep_rd[2] = 1'b1;
    cyc();
    bus_evt = '0; int_rd = 1'b0; ep_evt = '0; ep_rd = '0;
    chk("R5 set wins", 32'(rdata[STW-1:0]), (32'h1 << 3) | (32'h1 << 8));
    clr_all();

    // R7: global enable
    wr_cfg(1'b0, 1'b0);
    fire(0);
    cyc(); cyc();
    chk("R7 global mask", 32'(irq), 32'h0);
    wr_cfg(1'b1, 1'b0);
    cyc();
    chk("R7 global unmask", 32'(irq), 32'h1);
    clr_all();
    cyc();

    // R12: live bus status
    bus_status = 1'b1;
    #1;
    chk("R12 bus status high", 32'(rdata[STW]), 32'h1);
    bus_status = 1'b0;
    #1;
    chk("R12 bus status low", 32'(rdata[STW]), 32'h0);

    // R9: pulse mode
    wr_cfg(1'b1, 1'b1);
    fire(4);
    chk("R9 no pulse before rise seen", 32'(irq), 32'h0);
    n = 0;
    for (int k = 0; k < 3*PW; k++) begin
      cyc();
      if (k == 0) chk("R9 pulse starts", 32'(irq), 32'h1);
      n += int'(irq);
    end
    chk("R9 pulse width", 32'(n), 32'(PW));
    chk("R9 held request no repulse", 32'(irq), 32'h0);
    int_rd = 1'b1; cyc(); int_rd = 1'b0;
    fire(4);
    n = 0;
    for (int k = 0; k < 3*PW; k++) begin
      cyc();
      n += int'(irq);
    end
    chk("R9 second rise pulse width", 32'(n), 32'(PW));
    int_rd = 1'b1; cyc(); int_rd = 1'b0;
    cyc();

    // R10: no retrigger
    fire(5);
    n = 0;
    cyc(); n += int'(irq);
    int_rd = 1'b1; cyc(); int_rd = 1'b0; n += int'(irq);
    fire(5); n += int'(irq);
    for (int k = 0; k < 3*PW; k++) begin
      cyc();
      n += int'(irq);
    end
    chk("R10 pulse not extended", 32'(n), 32'(PW));
    chk("R10 line idle", 32'(irq), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule